// File: doc/BRIEF.md
# Gated Up-Counter Register Peripheral

This block is a small peripheral on a local register bus. It holds one register address. Behind that address are a 4-bit up-counter, an enable flag and the direction settings of five differential I/O channels. A host write to the address does three things. It loads the enable flag from bit 5 of the write data. It sets channels 0 to 3 to drive the counter bits. It leaves channel 4 as an input.

Channel 4 carries an external run/stop line. That line passes through a two-flop synchronizer. The counter advances by one on each clock edge where both the enable flag and the synchronized run/stop line are high, and it wraps from 15 to 0.

A read of the address returns a packed word: the count, the synchronized run/stop line and the enable flag.

Top module: `gated_counter_periph`

## Requirements
- R1: Only a write whose address equals 0x8020 changes the enable flag or the channel directions. Writes to any other address leave them unchanged.
- R2: A write request held high for several cycles at 0x8020 acts once, on its first cycle. The data presented in later cycles of the same request is ignored. A new request needs the write request (or the address match) to drop for at least one cycle.
- R3: A write at 0x8020 loads the enable flag from write-data bit 5. The flag is visible from the cycle after the accepting edge.
- R4: After a write at 0x8020, the output-enable vector chan_oe_o equals 5'b01111 (channels 0..3 outputs, channel 4 input). Channel 4 is never an output.
- R5: chan_out_o[i] equals count bit i for i = 0..3 while chan_oe_o[i] is 1, and is 0 otherwise. chan_out_o[4] is always 0.
- R6: On every rising clock edge where the enable flag is 1 and the synchronized channel-4 line is 1, the count increases by one.
- R7: The count wraps from 15 to 0. It holds its value on any edge where the enable flag or the synchronized channel-4 line is 0.
- R8: chan_in_i[4] reaches the counter and the read word only after two clock edges. chan_in_i[3:0] have no effect.
- R9: While rd_i is 1 and addr_i is 0x8020, rdata_o = {26'b0, enable, synchronized channel-4 line, count[3:0]}. Otherwise rdata_o is 0. Reads change no state.
- R10: While rst_ni is low, the count is 0, the enable flag is 0 and chan_oe_o is 0 (all channels inputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Register address |
| wr_i | input | 1 | Write request |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read request |
| rdata_o | output | 32 | Read data |
| chan_in_i | input | 5 | Channel input levels from the buffers |
| chan_out_o | output | 5 | Channel output levels to the buffers |
| chan_oe_o | output | 5 | Channel output enables (1 = drive) |

## Verification
The assertions assume that rst_ni is held low across at least one clock edge before use. They also assume that the bus inputs are valid, not X, at every edge after reset. The one-shot property further assumes that the write request is a level sampled once per cycle.

The stimulus drives every input only on the falling clock edge and keeps the reset low for several edges at the start. Write requests are sometimes held across several cycles with changing data, which exercises the one-shot behaviour without breaking these assumptions.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  parameter int unsigned ADDR_W   = 16;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned CNT_W    = 4;
  parameter int unsigned CHAN_N   = 5;
  parameter logic [ADDR_W-1:0] CNT_ADDR = 16'h8020;

  localparam int unsigned INC_BIT = CNT_W;      // read word: sync run line
  localparam int unsigned EN_BIT  = CNT_W + 1;  // read word / write data: enable
  localparam int unsigned RUN_CH  = CHAN_N - 1; // channel carrying run/stop

  // direction after a counter write: low CNT_W channels drive
  localparam logic [CHAN_N-1:0] OE_ACTIVE = CHAN_N'((1 << CNT_W) - 1);
endpackage

// File: rtl/gcp_decode.sv
module gcp_decode
  import gcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_stb_o,
  output logic              rd_sel_o
);
  logic addr_hit, wr_hit, wr_hit_q;

  assign addr_hit = (addr_i == CNT_ADDR);
  assign wr_hit   = wr_i && addr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_hit_q <= 1'b0;
    else         wr_hit_q <= wr_hit;
  end

  // one pulse per request
  assign wr_stb_o = wr_hit && !wr_hit_q;
  assign rd_sel_o = rd_i && addr_hit;

  // R2
  wr_oneshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  // R1
  wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (addr_i == CNT_ADDR) && wr_i);
endmodule

// File: rtl/gcp_sync.sv
module gcp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gcp_dir.sv
module gcp_dir
  import gcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CHAN_N-1:0] oe_o,
  output logic [CHAN_N-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_o <= '0;
    else if (wr_stb_i) oe_o <= OE_ACTIVE;
  end

  for (genvar i = 0; i < CHAN_N; i++) begin : g_chan
    if (i < CNT_W) begin : g_drv
      assign out_o[i] = oe_o[i] & cnt_i[i];
    end else begin : g_in
      assign out_o[i] = 1'b0;
    end
  end

  // R4
  oe_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) || (oe_o == OE_ACTIVE));

  // R4
  oe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> oe_o == OE_ACTIVE);

  // R5
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o == '0) |-> (out_o == '0));
endmodule

// File: rtl/gcp_count.sv
module gcp_count
  import gcp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic             en_bit_i,
  input  logic             run_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= 1'b0;
    else if (wr_stb_i) en_o <= en_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (en_o && run_i)  cnt_o <= cnt_o + 1'b1;
  end

  // R3
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> en_o == $past(en_bit_i));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && run_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_o && run_i) |=> $stable(cnt_o));
endmodule

// File: rtl/gated_counter_periph.sv
module gated_counter_periph
  import gcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CHAN_N-1:0] chan_in_i,
  output logic [CHAN_N-1:0] chan_out_o,
  output logic [CHAN_N-1:0] chan_oe_o
);
  logic             wr_stb, rd_sel, run_s, en_q;
  logic [CNT_W-1:0] cnt_q;

  gcp_decode u_dec (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i,
    .wr_stb_o (wr_stb),
    .rd_sel_o (rd_sel)
  );

  gcp_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i (chan_in_i[RUN_CH]),
    .q_o (run_s)
  );

  gcp_count u_cnt (
    .clk_i, .rst_ni,
    .wr_stb_i (wr_stb),
    .en_bit_i (wdata_i[EN_BIT]),
    .run_i    (run_s),
    .en_o     (en_q),
    .cnt_o    (cnt_q)
  );

  gcp_dir u_dir (
    .clk_i, .rst_ni,
    .wr_stb_i (wr_stb),
    .cnt_i    (cnt_q),
    .oe_o     (chan_oe_o),
    .out_o    (chan_out_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_sel) begin
      rdata_o[CNT_W-1:0] = cnt_q;
      rdata_o[INC_BIT]   = run_s;
      rdata_o[EN_BIT]    = en_q;
    end
  end

  // R9
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);

  // R9
  rd_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:EN_BIT+1] == '0);
endmodule

// File: tb/gated_counter_periph_tb.sv
module gated_counter_periph_tb_top;
  localparam logic [15:0] A_CNT = 16'h8020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  chin = '0, chout, choe;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gated_counter_periph dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .chan_in_i(chin), .chan_out_o(chout), .chan_oe_o(choe)
  );

  // reference model
  logic       m_s1, m_s2, m_en, m_prev;
  logic [3:0] m_cnt;
  logic [4:0] m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_en <= 0; m_prev <= 0; m_cnt <= 0; m_oe <= 0;
    end else begin
      logic hit;
      hit = wr && (addr == A_CNT);
      m_s1 <= chin[4];
      m_s2 <= m_s1;
      m_prev <= hit;
      if (hit && !m_prev) begin
        m_en <= wdata[5];
        m_oe <= 5'b01111;
      end
      if (m_en && m_s2) m_cnt <= m_cnt + 4'd1;
    end
  end

  function automatic logic [31:0] exp_rdata();
    if (rd && addr == A_CNT) return {26'b0, m_en, m_s2, m_cnt};
    return 32'b0;
  endfunction

  function automatic logic [4:0] exp_out();
    return {1'b0, m_cnt & m_oe[3:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R9 read word", rdata, exp_rdata());
    chk("R4 R1 R2 direction", {27'b0, choe}, {27'b0, m_oe});
    chk("R5 channel out", {27'b0, chout}, {27'b0, exp_out()});
  endtask

  // check current state, then drive next inputs
  task automatic cyc(logic w, logic [15:0] a, logic [31:0] d, logic r, logic [4:0] c);
    @(negedge clk);
    check_all();
    wr = w; addr = a; wdata = d; rd = r; chin = c;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    rd = 1'b1; addr = A_CNT;
    #1;
    chk("R10 reset read", rdata, 32'h0);
    chk("R10 reset oe", {27'b0, choe}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: write to another address, enable bit set, no effect
    cyc(1, 16'h8024, 32'h20, 1, 5'h10);
    cyc(0, A_CNT, 0, 1, 5'h10);
    cyc(0, A_CNT, 0, 1, 5'h10);
    chk("R1 no enable", {31'b0, rdata[5]}, 32'h0);

    // R3 enable, R6 R7 counting and wrap, R8 run line
    cyc(1, A_CNT, 32'h20, 1, 5'h10);
    cyc(0, A_CNT, 0, 1, 5'h10);
    for (int i = 0; i < 40; i++) cyc(0, A_CNT, 0, 1, 5'h10);
    // R8: drop run line and watch two-edge latency
    cyc(0, A_CNT, 0, 1, 5'h0F);
    for (int i = 0; i < 6; i++) cyc(0, A_CNT, 0, 1, 5'h0F);

    // R2: held write, later data clears enable but must be ignored
    cyc(1, A_CNT, 32'h20, 1, 5'h10);
    cyc(1, A_CNT, 32'h00, 1, 5'h10);
    cyc(1, A_CNT, 32'h00, 1, 5'h10);
    cyc(0, A_CNT, 0, 1, 5'h10);
    chk("R2 held write once", {31'b0, rdata[5]}, 32'h1);

    // disable via R3, count holds (R7)
    cyc(1, A_CNT, 32'h0, 1, 5'h10);
    for (int i = 0; i < 8; i++) cyc(0, A_CNT, 0, 1, 5'h10);

    // random phase
    begin
      logic       w = 0;
      logic [4:0] c = 0;
      for (int i = 0; i < 3000; i++) begin
        int unsigned r = $urandom % 16;
        logic [15:0] a;
        if (w && ($urandom % 2)) a = addr;
        else begin
          w = (r < 3);
          a = ($urandom % 3 != 0) ? A_CNT : 16'($urandom);
        end
        if ($urandom % 4 == 0) c[4] = ~c[4];
        c[3:0] = 4'($urandom);
        cyc(w, a, $urandom, 1'($urandom), c);
      end
    end

    cyc(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule